// File: doc/BRIEF.md
# Little-Endian Load/Store Byte-Lane Unit

This block sits between a processor datapath and a 32-bit memory bus that carries one write-enable bit per byte. On the store side it takes an access size, a byte address and a register value. It returns three things: the word-aligned bus address, the write data moved onto the correct byte lanes, and the per-lane enable mask.

On the load side it takes a load kind, the low address bits, the word returned by the bus and the current contents of the destination register. It returns the value to be written back. For sub-word loads that value is sign- or zero-extended. For the unaligned left and right loads, bytes from memory are merged into the old register contents.

Both halves are registered. A request accepted with its valid strobe appears on the outputs after the next rising clock edge. While no request is presented, the outputs hold their last values. Byte 0 of a word always occupies bits 7:0.

Top module: `lane_steer_unit`

## Requirements
- R1: One cycle after a store request, `st_bus_addr` equals the request byte address with bits 1:0 forced to zero, for every store kind.
- R2: Store kind 0 (byte) places data bits 7:0 on all four lanes. It enables only lane `addr[1:0]`, where lane n is `st_be` bit n and data bits 8n+7:8n.
- R3: Store kind 1 (halfword) places data bits 15:0 on both halves. It drives `st_be` = 4'b0011 when `addr[1]` is 0 and 4'b1100 when it is 1. `addr[0]` is ignored.
- R4: Store kind 2 (word) passes the data unchanged with `st_be` = 4'b1111, whatever the address low bits are, and raises no fault. Store kind 3 drives `st_be` = 4'b0000.
- R5: Load kind 0 sign-extends, and load kind 1 zero-extends, the memory byte at offset `ld_off` (bits 8*off+7:8*off) to 32 bits.
- R6: Load kind 2 sign-extends, and load kind 3 zero-extends, the memory halfword at bits 15:0 when `ld_off[1]` is 0 and at bits 31:16 when it is 1. `ld_off[0]` is ignored.
- R7: Load kinds 4 (word) and 7 return the memory word unchanged at every offset.
- R8: Load kind 5 (word-left) at offset k sets result bytes 3 down to 3-k from memory bytes k down to 0, and keeps the other low bytes of `ld_old`.
- R9: Load kind 6 (word-right) at offset k sets result bytes 3-k down to 0 from memory bytes 3 down to k, and keeps the other high bytes of `ld_old`.
- R10: Each output valid flag rises exactly one cycle after its request valid. The outputs hold their values while no request is given. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request strobe |
| st_kind | input | 2 | Store size: 0 byte, 1 halfword, 2 word, 3 none |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store register value |
| ld_valid | input | 1 | Load request strobe |
| ld_kind | input | 3 | Load kind: 0 sb, 1 ub, 2 sh, 3 uh, 4 word, 5 left, 6 right, 7 word |
| ld_off | input | 2 | Load byte offset within the word |
| ld_word | input | 32 | Word returned by the bus |
| ld_old | input | 32 | Old destination register value |
| st_out_valid | output | 1 | Store outputs updated |
| st_bus_addr | output | 32 | Word-aligned bus address |
| st_wdata | output | 32 | Lane-steered write data |
| st_be | output | 4 | Per-lane write enable |
| ld_out_valid | output | 1 | Load result updated |
| ld_result | output | 32 | Extended or merged load result |

## Verification
The assertions assume that the request inputs are stable across each rising edge. They also assume that `rst_n` is low for at least one edge before the first request, so that every `$past` value refers to a request actually sampled. The stimulus drives all inputs on the falling edge and holds both valids low during reset. It gaps requests at random, so the hold rule is covered. Every kind code and every offset is applied, including the unused store code 3 and the spare load code 7.

// File: rtl/lane_pkg.sv
// Shared encodings for the byte-lane unit.
// Assumes a little-endian bus where lane n carries bits 8n+7:8n.
package lane_pkg;
    typedef enum logic [1:0] {
        ST_BYTE = 2'd0,
        ST_HALF = 2'd1,
        ST_WORD = 2'd2,
        ST_NONE = 2'd3
    } st_kind_e;

    typedef enum logic [2:0] {
        LD_SBYTE = 3'd0,
        LD_UBYTE = 3'd1,
        LD_SHALF = 3'd2,
        LD_UHALF = 3'd3,
        LD_WORD  = 3'd4,
        LD_LEFT  = 3'd5,
        LD_RIGHT = 3'd6,
        LD_SPARE = 3'd7
    } ld_kind_e;
endpackage

// File: rtl/store_lane_steer.sv
// Store-side steering: aligns the address, replicates data onto lanes
// and builds the byte-enable mask. Purely combinational.
// Assumes DATA_W is a multiple of 16.
module store_lane_steer
    import lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  st_kind_e              kind,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     data,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     wdata,
    output logic [DATA_W/8-1:0]   be
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [OFF_W-1:0]   off;
    logic [DATA_W-1:0]  byte_rep;
    logic [DATA_W-1:0]  half_rep;
    logic [LANES-1:0]   byte_be;
    logic [LANES-1:0]   half_be;

    assign off      = addr[OFF_W-1:0];
    // Clear the in-word offset bits to form the bus address.
    assign bus_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    // Replicate the byte and halfword across every lane (pair).
    for (genvar g = 0; g < LANES; g++) begin : g_byte_rep
        assign byte_rep[8*g +: 8] = data[7:0];
        assign byte_be[g]         = (off == OFF_W'(g));
    end
    for (genvar h = 0; h < LANES/2; h++) begin : g_half_rep
        assign half_rep[16*h +: 16]  = data[15:0];
        assign half_be[2*h +: 2]     = {2{off[OFF_W-1:1] == (OFF_W-1)'(h)}};
    end

    // Pick data and enables by access size.
    always_comb begin
        unique case (kind)
            ST_BYTE: begin wdata = byte_rep; be = byte_be; end
            ST_HALF: begin wdata = half_rep; be = half_be; end
            ST_WORD: begin wdata = data;     be = '1;      end
            default: begin wdata = data;     be = '0;      end
        endcase
    end
endmodule

// File: rtl/load_lane_merge.sv
// Load-side extraction: selects, extends or merges bytes of the bus word
// into a register value. Purely combinational.
// Assumes DATA_W is a multiple of 16.
module load_lane_merge
    import lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  ld_kind_e                       kind,
    input  logic [$clog2(DATA_W/8)-1:0]    off,
    input  logic [DATA_W-1:0]              word,
    input  logic [DATA_W-1:0]              old,
    output logic [DATA_W-1:0]              result
);
    localparam int LANES = DATA_W / 8;

    logic [7:0]        sel_byte;
    logic [15:0]       sel_half;
    logic [DATA_W-1:0] left_val;
    logic [DATA_W-1:0] right_val;
    int                byte_sh;
    int                half_sh;
    int                left_sh;

    // Shift distances for the chosen offset.
    always_comb begin
        byte_sh = 8 * int'(off);
        half_sh = 16 * int'(off >> 1);
        left_sh = 8 * (LANES - 1 - int'(off));
    end

    // Extract the addressed byte and halfword.
    always_comb begin
        sel_byte = word[byte_sh +: 8];
        sel_half = word[half_sh +: 16];
    end

    // Build the left and right merges lane by lane.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (i >= LANES - 1 - int'(off))
                left_val[8*i +: 8] = word[8*(i - (LANES - 1 - int'(off))) +: 8];
            else
                left_val[8*i +: 8] = old[8*i +: 8];
            if (i <= LANES - 1 - int'(off))
                right_val[8*i +: 8] = word[8*(i + int'(off)) +: 8];
            else
                right_val[8*i +: 8] = old[8*i +: 8];
        end
    end

    // Choose the final value by load kind.
    always_comb begin
        unique case (kind)
            LD_SBYTE: result = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
            LD_UBYTE: result = {{(DATA_W-8){1'b0}}, sel_byte};
            LD_SHALF: result = {{(DATA_W-16){sel_half[15]}}, sel_half};
            LD_UHALF: result = {{(DATA_W-16){1'b0}}, sel_half};
            LD_LEFT:  result = left_val;
            LD_RIGHT: result = right_val;
            default:  result = word;
        endcase
    end

    logic unused_sh;
    assign unused_sh = ^left_sh;
endmodule

// File: rtl/lane_steer_unit.sv
// Top of the byte-lane unit: the store steering and load merging logic,
// each followed by one output register stage with a valid flag.
// Assumes requests are stable around the rising edge.
module lane_steer_unit
    import lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         st_valid,
    input  logic [1:0]                   st_kind,
    input  logic [ADDR_W-1:0]            st_addr,
    input  logic [DATA_W-1:0]            st_data,
    input  logic                         ld_valid,
    input  logic [2:0]                   ld_kind,
    input  logic [$clog2(DATA_W/8)-1:0]  ld_off,
    input  logic [DATA_W-1:0]            ld_word,
    input  logic [DATA_W-1:0]            ld_old,
    output logic                         st_out_valid,
    output logic [ADDR_W-1:0]            st_bus_addr,
    output logic [DATA_W-1:0]            st_wdata,
    output logic [DATA_W/8-1:0]          st_be,
    output logic                         ld_out_valid,
    output logic [DATA_W-1:0]            ld_result
);
    localparam int LANES = DATA_W / 8;

    logic [ADDR_W-1:0] n_addr;
    logic [DATA_W-1:0] n_wdata;
    logic [LANES-1:0]  n_be;
    logic [DATA_W-1:0] n_result;

    store_lane_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .kind     (st_kind_e'(st_kind)),
        .addr     (st_addr),
        .data     (st_data),
        .bus_addr (n_addr),
        .wdata    (n_wdata),
        .be       (n_be)
    );

    load_lane_merge #(.DATA_W(DATA_W)) u_load (
        .kind   (ld_kind_e'(ld_kind)),
        .off    (ld_off),
        .word   (ld_word),
        .old    (ld_old),
        .result (n_result)
    );

    // Register the store outputs on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_out_valid <= 1'b0;
            st_bus_addr  <= '0;
            st_wdata     <= '0;
            st_be        <= '0;
        end else begin
            st_out_valid <= st_valid;
            if (st_valid) begin
                st_bus_addr <= n_addr;
                st_wdata    <= n_wdata;
                st_be       <= n_be;
            end
        end
    end

    // Register the load result on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_out_valid <= 1'b0;
            ld_result    <= '0;
        end else begin
            ld_out_valid <= ld_valid;
            if (ld_valid)
                ld_result <= n_result;
        end
    end
endmodule

// File: rtl/lane_steer_unit_chk.sv
// Property checker for lane_steer_unit, bound to every instance.
// Assumes the default 32-bit data width.
module lane_steer_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        st_valid,
    input logic [1:0]  st_kind,
    input logic [31:0] st_addr,
    input logic [31:0] st_data,
    input logic        ld_valid,
    input logic [2:0]  ld_kind,
    input logic [1:0]  ld_off,
    input logic [31:0] ld_word,
    input logic        st_out_valid,
    input logic [31:0] st_bus_addr,
    input logic [31:0] st_wdata,
    input logic [3:0]  st_be,
    input logic        ld_out_valid,
    input logic [31:0] ld_result
);
    assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> (st_bus_addr == {$past(st_addr[31:2]), 2'b00}));

    assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_kind == 2'd0) |=> ($countones(st_be) == 1 && st_be[$past(st_addr[1:0])]));

    assert_half_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_kind == 2'd1) |=> (st_be == ($past(st_addr[1]) ? 4'b1100 : 4'b0011)));

    assert_word_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_kind == 2'd2) |=> (st_be == 4'hF && st_wdata == $past(st_data)));

    assert_ubyte_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_kind == 3'd1) |=> (ld_result[31:8] == 24'd0));

    assert_uhalf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_kind == 3'd3) |=> (ld_result[31:16] == 16'd0));

    assert_word_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_kind == 3'd4) |=> (ld_result == $past(ld_word)));

    assert_left_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_kind == 3'd5 && ld_off == 2'd3) |=> (ld_result == $past(ld_word)));

    assert_right_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_kind == 3'd6 && ld_off == 2'd0) |=> (ld_result == $past(ld_word)));

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_out_valid == $past(st_valid)) && (ld_out_valid == $past(ld_valid)));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> ($stable(st_wdata) && $stable(st_be) && $stable(st_bus_addr)));
endmodule

bind lane_steer_unit lane_steer_unit_chk u_chk (.*);

// File: tb/lane_steer_unit_test.sv
module lane_steer_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        st_valid;
    logic [1:0]  st_kind;
    logic [31:0] st_addr, st_data;
    logic        ld_valid;
    logic [2:0]  ld_kind;
    logic [1:0]  ld_off;
    logic [31:0] ld_word, ld_old;
    logic        st_out_valid, ld_out_valid;
    logic [31:0] st_bus_addr, st_wdata, ld_result;
    logic [3:0]  st_be;

    int vectors = 0;
    int misses  = 0;

    // Expected-value queues, one entry per request awaiting its edge.
    logic [31:0] q_addr[$], q_wdata[$], q_res[$];
    logic [3:0]  q_be[$];
    string       q_stag[$], q_ltag[$];

    logic [31:0] e_addr = 0, e_wdata = 0, e_res = 0;
    logic [3:0]  e_be = 0;
    logic        e_sv = 0, e_lv = 0;
    string       stag = "R10", ltag = "R10";

    lane_steer_unit uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog R10: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    function automatic logic [31:0] sext8(input logic [7:0] b);
        int v = b;
        if (v > 127) v -= 256;
        return 32'(v);
    endfunction

    function automatic logic [31:0] sext16(input logic [15:0] h);
        int v = h;
        if (v > 32767) v -= 65536;
        return 32'(v);
    endfunction

    // Model the store side behaviourally and queue the result.
    task automatic model_store(input int kind, input logic [31:0] a, input logic [31:0] d);
        logic [31:0] w;
        logic [3:0] b;
        int k = a % 4;
        case (kind)
            0: begin w = {4{d[7:0]}}; b = 4'(1 << k); end
            1: begin w = {2{d[15:0]}}; b = (k >= 2) ? 4'b1100 : 4'b0011; end
            2: begin w = d; b = 4'b1111; end
            default: begin w = d; b = 4'b0000; end
        endcase
        q_addr.push_back(a - 32'(k));
        q_wdata.push_back(w);
        q_be.push_back(b);
        q_stag.push_back(kind == 0 ? "R2" : kind == 1 ? "R3" : "R4");
    endtask

    // Model the load side behaviourally and queue the result.
    task automatic model_load(input int kind, input int k, input logic [31:0] m, input logic [31:0] o);
        logic [31:0] r;
        logic [7:0] mb[4], ob[4], rb[4];
        for (int i = 0; i < 4; i++) begin mb[i] = m[8*i +: 8]; ob[i] = o[8*i +: 8]; end
        case (kind)
            0: r = sext8(mb[k]);
            1: r = {24'd0, mb[k]};
            2: r = sext16({mb[(k/2)*2+1], mb[(k/2)*2]});
            3: r = {16'd0, mb[(k/2)*2+1], mb[(k/2)*2]};
            5: begin
                for (int i = 0; i < 4; i++) rb[i] = (i >= 3 - k) ? mb[i - (3 - k)] : ob[i];
                r = {rb[3], rb[2], rb[1], rb[0]};
            end
            6: begin
                for (int i = 0; i < 4; i++) rb[i] = (i <= 3 - k) ? mb[i + k] : ob[i];
                r = {rb[3], rb[2], rb[1], rb[0]};
            end
            default: r = m;
        endcase
        q_res.push_back(r);
        q_ltag.push_back(kind < 2 ? "R5" : kind < 4 ? "R6" : kind == 5 ? "R8" : kind == 6 ? "R9" : "R7");
    endtask

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // After each rising edge: retire queued expectations and compare all outputs.
    task automatic compare_cycle();
        bit sv = q_addr.size() > 0;
        bit lv = q_res.size() > 0;
        if (sv) begin
            e_addr = q_addr.pop_front(); e_wdata = q_wdata.pop_front();
            e_be = q_be.pop_front(); stag = q_stag.pop_front();
        end else stag = "R10";
        if (lv) begin
            e_res = q_res.pop_front(); ltag = q_ltag.pop_front();
        end else ltag = "R10";
        e_sv = sv; e_lv = lv;
        chk32("R10", {31'd0, st_out_valid}, {31'd0, e_sv});
        chk32("R10", {31'd0, ld_out_valid}, {31'd0, e_lv});
        chk32(sv ? "R1" : "R10", st_bus_addr, e_addr);
        chk32(stag, st_wdata, e_wdata);
        chk32(stag, {28'd0, st_be}, {28'd0, e_be});
        chk32(ltag, ld_result, e_res);
    endtask

    task automatic step(input bit sv, input int sk, input logic [31:0] a, input logic [31:0] d,
                        input bit lv, input int lk, input int k, input logic [31:0] m, input logic [31:0] o);
        st_valid = sv; st_kind = 2'(sk); st_addr = a; st_data = d;
        ld_valid = lv; ld_kind = 3'(lk); ld_off = 2'(k); ld_word = m; ld_old = o;
        if (sv) model_store(sk, a, d);
        if (lv) model_load(lk, k, m, o);
        @(negedge clk);
        compare_cycle();
    endtask

    initial begin
        rst_n = 1'b0;
        st_valid = 0; st_kind = 0; st_addr = 0; st_data = 0;
        ld_valid = 0; ld_kind = 0; ld_off = 0; ld_word = 0; ld_old = 0;
        repeat (3) @(negedge clk);
        // R10: reset state of every output.
        chk32("R10", {31'd0, st_out_valid}, 32'd0);
        chk32("R10", {31'd0, ld_out_valid}, 32'd0);
        chk32("R10", st_bus_addr, 32'd0);
        chk32("R10", st_wdata, 32'd0);
        chk32("R10", {28'd0, st_be}, 32'd0);
        chk32("R10", ld_result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_cycle();

        // Directed sweep: every store kind and load kind at every offset.
        for (int sk = 0; sk < 4; sk++)
            for (int k = 0; k < 4; k++)
                step(1, sk, 32'hBFC0_0010 + 32'(k), 32'h8899_A1F2, 0, 0, 0, 0, 0);
        for (int lk = 0; lk < 8; lk++)
            for (int k = 0; k < 4; k++)
                step(0, 0, 0, 0, 1, lk, k, 32'h80F7_7E81, 32'h1234_5678);

        // Idle cycles: outputs must hold (R10).
        repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, 0);

        // Random mix with gaps.
        for (int n = 0; n < 400; n++) begin
            step(($urandom % 4) != 0, int'($urandom % 4), $urandom, $urandom,
                 ($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 4), $urandom, $urandom);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule